// File: doc/BRIEF.md
# Relocatable Register/RAM Address Decoder

This block sits between a 16-bit bus master and the memories of a small microcontroller. Each cycle it looks at the bus address and raises exactly one of four region selects: the on-chip register window, the on-chip EEPROM, the on-chip RAM or the external RAM. It also returns the byte offset of the address inside the selected region. When regions overlap, the one higher in a fixed order wins. An address that lands in no region gives a one-cycle error pulse.

The register window and the on-chip RAM are not pinned in place. An 8-bit placement register holds two 4-bit page numbers. The low nibble places the register window and the high nibble places the RAM, each on a 4 KB boundary. The placement register sits inside the register window at a fixed offset, so software moves the window by writing to it through the bus. A new placement applies from the next bus cycle. The EEPROM and the external RAM stay at fixed, parameterised addresses.

Top module: `addrDecTop`

## Requirements
- R1: After reset the placement register reads 0x01, which puts the RAM at page 0 (0x0000) and the register window at page 1 (0x1000). No select and no error is raised while reset is held.
- R2: The register window starts at {placement[3:0], 12'h000} and covers 64 bytes. An access there raises selIo, and regionOffset is the address minus that start (0x00 to 0x3F).
- R3: The RAM starts at {placement[7:4], 12'h000} and covers 2048 bytes. An access there raises selRam, and regionOffset is the address minus that start.
- R4: The EEPROM covers 0xB600 to 0xB7FF with offset address minus 0xB600. The external RAM covers 0x2000 to 0x7FFF with offset address minus 0x2000.
- R5: When regions overlap, one fixed order picks the winner: the register window first, then EEPROM, then RAM, then external RAM. At most one select is high at any time.
- R6: A valid access that hits no region raises no select. On the following cycle busError is high for exactly that one cycle.
- R7: A valid write to the register window at offset 0x3D loads busWdata into the placement register, and initValue shows it from the next cycle. Decoding in the same cycle still uses the old placement. Accesses from the next cycle on use the new placement.
- R8: A read at offset 0x3D, or a write to any other offset of the register window, leaves the placement register unchanged.
- R9: While busValid is low, all selects are low, regionOffset is zero and no error follows.
- R10: Whenever no select is high, regionOffset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Bus byte address |
| busValid | input | 1 | Access present this cycle |
| busWrite | input | 1 | Access is a write |
| busWdata | input | 8 | Write data |
| selIo | output | 1 | Register window selected |
| selEeprom | output | 1 | EEPROM selected |
| selRam | output | 1 | On-chip RAM selected |
| selExt | output | 1 | External RAM selected |
| regionOffset | output | 16 | Byte offset within the selected region |
| busError | output | 1 | Previous cycle's valid access hit nothing |
| initValue | output | 8 | Current placement register |

## Verification
The bench places the register window on the same page as the RAM. A decoder with the wrong priority would then hand the window addresses to the RAM, and the bench catches that. The RAM is then moved over the EEPROM page and over the external RAM range, to show that the EEPROM beats the RAM and the RAM beats the external RAM. The bench probes both ends of every region and the first byte past the register window. Off-by-one limits would turn those probes into false hits or false errors. Writes to the neighbours of the placement offset, a read of that offset, and an access on the cycle right after a placement write are also covered. These catch decoders that load on the wrong strobe or apply a new placement a cycle early or late.

// File: rtl/addrDecPkg.sv
package addrDecPkg;
  localparam int NUM_RGN = 4;

  typedef enum logic [1:0] {
    RGN_IO  = 2'd0,
    RGN_EE  = 2'd1,
    RGN_RAM = 2'd2,
    RGN_EXT = 2'd3
  } region_e;

  typedef struct packed {
    logic [NUM_RGN-1:0] grant;
    logic               loadInit;
    logic               flagErr;
  } decStrobe_t;
endpackage

// File: rtl/addrDecDp.sv
module addrDecDp
  import addrDecPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IO_W = 6,
  parameter int RAM_W = 11,
  parameter int EE_W = 9,
  parameter logic [ADDR_W-1:0] EE_BASE = 16'hB600,
  parameter logic [ADDR_W-1:0] EXT_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] EXT_HI = 16'h7FFF,
  parameter logic [IO_W-1:0] INIT_OFS = 6'h3D,
  parameter logic [7:0] INIT_RST = 8'h01
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [7:0]         busWdata,
  input  decStrobe_t         strobe,
  output logic [NUM_RGN-1:0] hitVec,
  output logic               initHit,
  output logic [ADDR_W-1:0]  regionOffset,
  output logic               busError,
  output logic [7:0]         initValue
);
  localparam int PAGE_W = 4;
  localparam int LOW_W = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] EE_LAST = EE_BASE + ADDR_W'((1 << EE_W) - 1);

  logic [7:0] initReg;
  logic [ADDR_W-1:0] baseArr [NUM_RGN];
  logic [ADDR_W-1:0] offTerm [NUM_RGN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReg  <= INIT_RST;
      busError <= 1'b0;
    end else begin
      if (strobe.loadInit) initReg <= busWdata;
      busError <= strobe.flagErr;
    end
  end

  assign initValue = initReg;

  assign baseArr[RGN_IO]  = {initReg[PAGE_W-1:0], {LOW_W{1'b0}}};
  assign baseArr[RGN_RAM] = {initReg[7:PAGE_W], {LOW_W{1'b0}}};
  assign baseArr[RGN_EE]  = EE_BASE;
  assign baseArr[RGN_EXT] = EXT_LO;

  always_comb begin
    hitVec = '0;
    hitVec[RGN_IO]  = (busAddr[ADDR_W-1:LOW_W] == initReg[PAGE_W-1:0]) &&
                      (busAddr[LOW_W-1:IO_W] == '0);
    hitVec[RGN_RAM] = (busAddr[ADDR_W-1:LOW_W] == initReg[7:PAGE_W]) &&
                      (busAddr[LOW_W-1:RAM_W] == '0);
    hitVec[RGN_EE]  = (busAddr >= EE_BASE) && (busAddr <= EE_LAST);
    hitVec[RGN_EXT] = (busAddr >= EXT_LO) && (busAddr <= EXT_HI);
  end

  assign initHit = busAddr[IO_W-1:0] == INIT_OFS;

  genvar r;
  generate
    for (r = 0; r < NUM_RGN; r++) begin : gOff
      assign offTerm[r] = strobe.grant[r] ? (busAddr - baseArr[r]) : '0;
    end
  endgenerate

  always_comb begin
    regionOffset = '0;
    for (int i = 0; i < NUM_RGN; i++) regionOffset = regionOffset | offTerm[i];
  end

  // R8: placement register changes only on a load strobe
  a_r8_init_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadInit |=> $stable(initReg));
  // R7: a load strobe makes the register take the write data
  a_r7_init_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInit |=> initReg == $past(busWdata));
endmodule

// File: rtl/addrDecCtrl.sv
module addrDecCtrl
  import addrDecPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [NUM_RGN-1:0] hitVec,
  input  logic               initHit,
  output decStrobe_t         strobe
);
  logic [NUM_RGN-1:0] grantVec;

  always_comb begin
    grantVec = '0;
    if (busValid) begin
      for (int i = NUM_RGN - 1; i >= 0; i--) begin
        if (hitVec[i]) grantVec = NUM_RGN'(1) << i;
      end
    end
  end

  assign strobe.grant    = grantVec;
  assign strobe.loadInit = busValid && busWrite && grantVec[RGN_IO] && initHit;
  assign strobe.flagErr  = busValid && (hitVec == '0);

  // R5: never more than one grant
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.grant));
  // R5: register window wins whenever it is hit
  a_r5_io_first: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && hitVec[RGN_IO]) |-> strobe.grant[RGN_IO]);
  // R9: no grant without a valid access
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> strobe.grant == '0 && !strobe.flagErr);
endmodule

// File: rtl/addrDecTop.sv
module addrDecTop
  import addrDecPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IO_W = 6,
  parameter int RAM_W = 11,
  parameter int EE_W = 9,
  parameter logic [ADDR_W-1:0] EE_BASE = 16'hB600,
  parameter logic [ADDR_W-1:0] EXT_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] EXT_HI = 16'h7FFF,
  parameter logic [IO_W-1:0] INIT_OFS = 6'h3D,
  parameter logic [7:0] INIT_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [7:0]        busWdata,
  output logic              selIo,
  output logic              selEeprom,
  output logic              selRam,
  output logic              selExt,
  output logic [ADDR_W-1:0] regionOffset,
  output logic              busError,
  output logic [7:0]        initValue
);
  decStrobe_t strobe;
  logic [NUM_RGN-1:0] hitVec;
  logic initHit;

  addrDecCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .hitVec(hitVec), .initHit(initHit), .strobe(strobe)
  );

  addrDecDp #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .RAM_W(RAM_W), .EE_W(EE_W),
    .EE_BASE(EE_BASE), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI),
    .INIT_OFS(INIT_OFS), .INIT_RST(INIT_RST)
  ) uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .hitVec(hitVec), .initHit(initHit),
    .regionOffset(regionOffset), .busError(busError), .initValue(initValue)
  );

  assign selIo     = strobe.grant[RGN_IO];
  assign selEeprom = strobe.grant[RGN_EE];
  assign selRam    = strobe.grant[RGN_RAM];
  assign selExt    = strobe.grant[RGN_EXT];

  // R6: an error pulse follows only a valid access that raised no select
  a_r6_err_after_miss: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !(selIo || selEeprom || selRam || selExt)) |=> busError);
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    busError |-> $past(busValid) && !$past(selIo || selEeprom || selRam || selExt));
  // R10: offset is zero when nothing is selected
  a_r10_zero_offset: assert property (@(posedge clk) disable iff (!rstN)
    !(selIo || selEeprom || selRam || selExt) |-> regionOffset == '0);
endmodule

// File: tb/tb_addrDecTop.sv
module tb_addrDecTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busValid = 1'b0;
  logic busWrite = 1'b0;
  logic [7:0] busWdata = '0;
  logic selIo, selEeprom, selRam, selExt, busError;
  logic [15:0] regionOffset;
  logic [7:0] initValue;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int mInit = 8'h01;
  bit mErr = 0;

  always #10 clk = ~clk;

  addrDecTop dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busValid(busValid),
    .busWrite(busWrite), .busWdata(busWdata), .selIo(selIo),
    .selEeprom(selEeprom), .selRam(selRam), .selExt(selExt),
    .regionOffset(regionOffset), .busError(busError), .initValue(initValue)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference: returns region index 0=io 1=eeprom 2=ram 3=ext, -1 for none
  function automatic int refRegion(input int a, input int init, output int off);
    int ioB = (init & 15) * 4096;
    int ramB = ((init >> 4) & 15) * 4096;
    off = 0;
    if (a >= ioB && a < ioB + 64) begin off = a - ioB; return 0; end
    if (a >= 'hB600 && a <= 'hB7FF) begin off = a - 'hB600; return 1; end
    if (a >= ramB && a < ramB + 2048) begin off = a - ramB; return 2; end
    if (a >= 'h2000 && a <= 'h7FFF) begin off = a - 'h2000; return 3; end
    return -1;
  endfunction

  task automatic access(input string req, input int a, input bit v, input bit w, input int d);
    int rg, off, selCode, expSel, nextInit;
    bit nextErr;
    @(negedge clk);
    busAddr = 16'(a); busValid = v; busWrite = w; busWdata = 8'(d);
    #3;
    rg = v ? refRegion(a, mInit, off) : -1;
    if (!v) off = 0;
    expSel = (rg < 0) ? 0 : (1 << rg);
    selCode = {28'd0, selExt, selRam, selEeprom, selIo};
    check(req, "selects", selCode, expSel);
    check(req, "offset", int'(regionOffset), off);
    check(req, "busError", int'(busError), int'(mErr));
    check(req, "initValue", int'(initValue), mInit);
    nextErr = v && (rg < 0);
    nextInit = (v && w && rg == 0 && off == 'h3D) ? (d & 255) : mInit;
    @(posedge clk);
    #1;
    mErr = nextErr;
    mInit = nextInit;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #35;
    check("R1", "reset initValue", int'(initValue), 8'h01);
    check("R1", "reset selects", int'({selExt, selRam, selEeprom, selIo}), 0);
    check("R1", "reset busError", int'(busError), 0);
    @(negedge clk); rstN = 1'b1;
    access("R9", 'h1005, 0, 0, 0);
    access("R2", 'h1005, 1, 0, 0);
    access("R2", 'h1000, 1, 0, 0);
    access("R2", 'h103F, 1, 0, 0);
    access("R6", 'h1040, 1, 0, 0);
    access("R6", 'h1041, 1, 0, 0);
    access("R6", 'h0010, 1, 0, 0);
    access("R3", 'h0000, 1, 0, 0);
    access("R3", 'h07FF, 1, 0, 0);
    access("R6", 'h0800, 1, 0, 0);
    access("R4", 'hB600, 1, 0, 0);
    access("R4", 'hB7FF, 1, 0, 0);
    access("R4", 'hB800, 1, 0, 0);
    access("R4", 'h2000, 1, 0, 0);
    access("R4", 'h7FFF, 1, 0, 0);
    access("R10", 'h9000, 1, 1, 'h55);
    access("R9", 'h9000, 0, 0, 0);
    access("R8", 'h103D, 1, 0, 'h44);
    access("R8", 'h103C, 1, 1, 'h44);
    access("R8", 'h103E, 1, 1, 'h44);
    // move both onto page 1: register window must win over RAM
    access("R7", 'h103D, 1, 1, 'h11);
    access("R7", 'h103D, 1, 0, 0);
    access("R5", 'h1020, 1, 0, 0);
    access("R5", 'h1040, 1, 0, 0);
    access("R3", 'h17FF, 1, 0, 0);
    // RAM to page 3 over the external range; window to page 4
    access("R7", 'h103D, 1, 1, 'h34);
    access("R5", 'h3010, 1, 0, 0);
    access("R5", 'h3800, 1, 0, 0);
    access("R2", 'h403F, 1, 0, 0);
    // RAM over the EEPROM page
    access("R7", 'h403D, 1, 1, 'hB4);
    access("R5", 'hB600, 1, 0, 0);
    access("R5", 'hB5FF, 1, 0, 0);
    access("R6", 'hB800, 1, 0, 0);
    access("R8", 'h0000, 1, 1, 0);
    access("R9", 'h0000, 0, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule